// File: doc/BRIEF.md
# Codec Power-Up Register Sequencer

This block runs the power-up programming order for an audio codec. One start pulse sends a fixed series of register write commands to a downstream serial-bus master. Each command carries a 7-bit register index and a 9-bit data word. The commands pass through a valid/ready handshake. The block does not drive any bus wires itself. A parameter table supplies the configuration writes.

The order guards the analog output. First the power register is written with every needed supply enabled and the output path still disabled. Then the configuration table goes out in order. Next the block waits a programmable number of clock cycles so the reference decoupling capacitor can charge. After that wait it sets the activate bit. The last write enables the output path. Then the block pulses done and returns to idle.

Top module: `codec_pwrup_seq`

## Requirements
- R1: While rst_ni is low and after release, cmd_valid_o, busy_o and done_o are 0.
- R2: The first command after start has index 6 and data PWR_ON_VAL with bit 4 forced to 1.
- R3: The next N_CFG commands are the CFG_TABLE entries in ascending entry order. Entry k sits at bits [16k+15:16k], with the index in the upper 7 bits and the data in the lower 9 bits.
- R4: While cmd_valid_o is high and cmd_ready_i is low, the command stays on the outputs unchanged. The block moves to the next command only on a cycle where valid and ready are both high.
- R5: After the last table handshake, cmd_valid_o stays low for exactly SETTLE_CYCLES cycles.
- R6: After the wait, the next command has index 9 and data 9'h001.
- R7: The final command has index 6 and data PWR_ON_VAL with bit 4 cleared. No earlier command writes index 6 with bit 4 at 0.
- R8: done_o pulses for one cycle, in the cycle right after the final handshake. busy_o is high from the cycle after start through the done cycle, and low after it.
- R9: A start pulse is ignored while busy_o is high, including the done cycle. The command series is unchanged and no new run begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| cmd_ready_i | input | 1 | Downstream master accepts the command |
| cmd_valid_o | output | 1 | Command present |
| cmd_reg_o | output | 7 | Register index of the command |
| cmd_data_o | output | 9 | Register data of the command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives cmd_ready_i with random back-pressure of several densities, so every command must survive stalls. A design that advanced without a handshake would drop or repeat table entries. A design that changed the command while stalled would break the hold check. The bench measures the silent gap before the activate write, which catches an off-by-one settle counter and any write issued during the wait. It also pulses start during the wait and in the done cycle. A design that restarted would show extra commands or busy staying high. It resets the block in the middle of a run to check the return to idle. The order of the two power-register writes is checked by value, so a design that enabled the output early would write index 6 with bit 4 at 0 in the wrong position.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;
  localparam int REG_IDX_W = 7;
  localparam int REG_DAT_W = 9;
  localparam int CMD_W     = REG_IDX_W + REG_DAT_W;
  localparam logic [REG_IDX_W-1:0] PWR_REG = 7'd6;
  localparam logic [REG_IDX_W-1:0] ACT_REG = 7'd9;
  localparam logic [REG_DAT_W-1:0] OUT_OFF_MASK = 9'h010;
  localparam logic [REG_DAT_W-1:0] ACT_ON_VAL   = 9'h001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CFG, ST_WAIT, ST_ACT, ST_OUT, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/codec_seq_cmd.sv
module codec_seq_cmd
  import codec_seq_pkg::*;
#(
  parameter int N_CFG = 4,
  parameter logic [N_CFG*CMD_W-1:0] CFG_TABLE = '0,
  parameter logic [REG_DAT_W-1:0] PWR_ON_VAL = '0,
  parameter int IDX_W = 3
) (
  input  seq_state_e             state_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [REG_IDX_W-1:0]   reg_o,
  output logic [REG_DAT_W-1:0]   data_o
);
  logic [CMD_W-1:0] entry;

  always_comb begin
    entry = '0;
    for (int k = 0; k < N_CFG; k++) begin
      if (idx_i == IDX_W'(k + 1)) entry = CFG_TABLE[k*CMD_W +: CMD_W];
    end
  end

  always_comb begin
    reg_o  = '0;
    data_o = '0;
    case (state_i)
      ST_CFG: begin
        if (idx_i == '0) begin
          reg_o  = PWR_REG;
          data_o = PWR_ON_VAL | OUT_OFF_MASK;  // output stays off
        end else begin
          reg_o  = entry[CMD_W-1:REG_DAT_W];
          data_o = entry[REG_DAT_W-1:0];
        end
      end
      ST_ACT: begin
        reg_o  = ACT_REG;
        data_o = ACT_ON_VAL;
      end
      ST_OUT: begin
        reg_o  = PWR_REG;
        data_o = PWR_ON_VAL & ~OUT_OFF_MASK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/codec_seq_timer.sv
module codec_seq_timer #(
  parameter int SETTLE_CYCLES = 1000,
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic running_o,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= CNT_W'(SETTLE_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign running_o = (cnt_q != '0);
  assign expired_o = (cnt_q == CNT_W'(1));

  AST_TIMER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == CNT_W'(SETTLE_CYCLES)); // R5
  AST_TIMER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
endmodule

// File: rtl/codec_pwrup_seq.sv
module codec_pwrup_seq
  import codec_seq_pkg::*;
#(
  parameter int N_CFG = 4,
  parameter logic [N_CFG*CMD_W-1:0] CFG_TABLE =
    {16'h0E0A, 16'h0812, 16'h0479, 16'h0017},
  parameter logic [REG_DAT_W-1:0] PWR_ON_VAL = 9'h062,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  cmd_ready_i,
  output logic                  cmd_valid_o,
  output logic [REG_IDX_W-1:0]  cmd_reg_o,
  output logic [REG_DAT_W-1:0]  cmd_data_o,
  output logic                  busy_o,
  output logic                  done_o
);
  localparam int IDX_W = $clog2(N_CFG + 2);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             hs, last_cfg, tmr_load, tmr_running, tmr_expired;

  assign hs       = cmd_valid_o && cmd_ready_i;
  assign last_cfg = (idx_q == IDX_W'(N_CFG));
  assign tmr_load = (state_q == ST_CFG) && hs && last_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CFG;
          idx_q   <= '0;
        end
        ST_CFG: if (hs) begin
          if (last_cfg) state_q <= ST_WAIT;
          else          idx_q   <= idx_q + 1'b1;
        end
        ST_WAIT: if (tmr_expired) state_q <= ST_ACT;
        ST_ACT:  if (hs) state_q <= ST_OUT;
        ST_OUT:  if (hs) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state_q == ST_CFG) || (state_q == ST_ACT) || (state_q == ST_OUT);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  codec_seq_cmd #(
    .N_CFG(N_CFG), .CFG_TABLE(CFG_TABLE), .PWR_ON_VAL(PWR_ON_VAL), .IDX_W(IDX_W)
  ) u_cmd (
    .state_i(state_q), .idx_i(idx_q), .reg_o(cmd_reg_o), .data_o(cmd_data_o)
  );

  codec_seq_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .running_o(tmr_running), .expired_o(tmr_expired)
  );

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o && $stable(cmd_reg_o) && $stable(cmd_data_o)); // R4
  AST_QUIET_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_running |-> !cmd_valid_o); // R5
  AST_ACT_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmd_valid_o) && cmd_reg_o == ACT_REG) |-> $past(tmr_expired)); // R6
  AST_OUT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_reg_o == PWR_REG && !cmd_data_o[4] && state_q != ST_CFG)
      |-> (state_q == ST_OUT)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !done_o) |=> busy_o); // R9
endmodule

// File: tb/codec_pwrup_seq_test.sv
module codec_pwrup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_CFG  = 4;
  localparam int SETTLE = 25;
  localparam logic [8:0] PWR = 9'h062;
  localparam logic [N_CFG*16-1:0] TABLE = {16'h0E0A, 16'h0812, 16'h0479, 16'h0017};
  localparam int N_CMD = N_CFG + 3;

  logic clk = 0, rst_n = 0, start = 0, ready = 0;
  logic valid, busy, done;
  logic [6:0] creg;
  logic [8:0] cdat;

  int checks = 0, failures = 0, cycles = 0;
  int mode = 0, n_rec = 0, gap = 0, gap_res = -1;
  bit gap_on = 0, hold_pend = 0, last_flag = 0, after_done = 0, mon_en = 0;
  logic [15:0] held;
  logic [15:0] rec [0:15];

  codec_pwrup_seq #(.N_CFG(N_CFG), .CFG_TABLE(TABLE), .PWR_ON_VAL(PWR),
                    .SETTLE_CYCLES(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_ready_i(ready),
    .cmd_valid_o(valid), .cmd_reg_o(creg), .cmd_data_o(cdat),
    .busy_o(busy), .done_o(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cmd(input int k);
    if (k == 0)          return {7'd6, PWR | 9'h010};
    else if (k <= N_CFG) return TABLE[(k-1)*16 +: 16];
    else if (k == N_CFG+1) return {7'd9, 9'h001};
    else                 return {7'd6, PWR & ~9'h010};
  endfunction

  function automatic string req_of(input int k);
    if (k == 0) return "R2";
    else if (k <= N_CFG) return "R3";
    else if (k == N_CFG+1) return "R6";
    else return "R7";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // monitor and ready driver
  always @(negedge clk) begin
    if (!rst_n || !mon_en) begin
      hold_pend = 0; gap_on = 0; last_flag = 0; after_done = 0; ready = 0;
    end else begin
      if (last_flag) begin
        check(done && busy, "R8 done after final handshake", {done, busy}, 2'b11);
        last_flag = 0; after_done = 1;
      end else if (after_done) begin
        check(!done && !busy, "R8 idle after done", {done, busy}, 2'b00);
        after_done = 0;
      end
      if (hold_pend)
        check(valid && {creg, cdat} == held, "R4 hold while stalled", {valid, creg, cdat}, {1'b1, held});
      if (gap_on) begin
        if (valid) begin gap_res = gap; gap_on = 0; end
        else gap++;
      end
      case (mode)
        0: ready = 1;
        1: ready = ($urandom % 2) == 0;
        default: ready = ($urandom % 4) == 0;
      endcase
      hold_pend = valid && !ready;
      held = {creg, cdat};
      if (valid && ready) begin
        if (n_rec < 16) rec[n_rec] = {creg, cdat};
        if (n_rec == N_CFG) begin gap_on = 1; gap = 0; end
        n_rec++;
        if (n_rec == N_CMD) last_flag = 1;
      end
    end
  end

  task automatic run_seq(input int m, input bit inject);
    int t;
    mode = m; n_rec = 0; gap_res = -1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy, "R8 busy after start", busy, 1);
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      if (!done) check(busy, "R8 busy during run", busy, 1);
      if (inject && (t == 3 || (gap_on && gap == 5))) start = 1;
      else start = 0;
    end
    if (inject) start = 1;  // pulse in the done cycle
    @(negedge clk); start = 0;
    @(negedge clk); @(negedge clk);
    check(n_rec == N_CMD, "R9 command count", n_rec, N_CMD);
    for (int k = 0; k < N_CMD && k < 16; k++)
      check(rec[k] == exp_cmd(k), req_of(k), rec[k], exp_cmd(k));
    check(gap_res == SETTLE, "R5 settle gap", gap_res, SETTLE);
    check(!valid && !busy && !done, "R9 no restart", {valid, busy, done}, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!valid && !busy && !done, "R1 in reset", {valid, busy, done}, 0);
    rst_n = 1; mon_en = 1;
    @(negedge clk);
    check(!valid && !busy && !done, "R1 after release", {valid, busy, done}, 0);
    run_seq(0, 0);
    run_seq(1, 1);
    run_seq(2, 0);
    run_seq(1, 0);
    run_seq(2, 1);
    // reset in mid-run
    mode = 2; n_rec = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(!valid && !busy && !done, "R1 mid-run reset", {valid, busy, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!valid && !busy, "R1 stays idle", {valid, busy}, 0);
    run_seq(0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule